// File: doc/BRIEF.md
# Interrupt Request Controller with Halt Wake

This block gathers fourteen single-bit request lines from peripherals into a sticky pending register. A processor drives it through a small synchronous register bus. The processor sets a per-source enable mask, acknowledges pending flags by writing ones, and switches a global master gate. The block drives two outputs:

- an interrupt line to the processor, which the master gate qualifies;
- a halt-wake line, which only needs an enabled pending flag and does not look at the master gate.

The block also keeps a 32-bit lateness record. Each cycle that carries at least one request, the block folds in the lateness value reported with it and keeps the larger of the stored and reported values. The processor reads the record on a dedicated port, and a take strobe empties it.

Top module: `irq_hub`

## Requirements
- R1: After reset, and on any read until a later write or request, the enable, pending and master registers read 0. The lateness record reads 0, and `cpu_irq` and `halt_wake` are low.
- R2: A high `src_req[i]` sets pending bit i at the next clock edge, and the bit stays set after the request drops. The fixed source positions are:
  - bit 0: vertical blank
  - bit 1: horizontal blank
  - bit 2: line match
  - bits 3..6: timers 0..3
  - bit 7: serial
  - bits 8..11: DMA 0..3
  - bit 12: keypad
  - bit 13: cartridge
- R3: A write to address 0 loads the enable register from `bus_wdata[13:0]`. A read of address 0 returns the enable register with bits 15:14 always 0.
- R4: A write to address 1 clears every pending bit whose written bit is 1 and leaves the others unchanged. Written zeros never set a bit. A read of address 1 returns the pending flags with bits 15:14 at 0.
- R5: When a request and an acknowledge hit the same pending bit in the same cycle, the bit ends up set.
- R6: A write to address 2 stores only `bus_wdata[0]` as the master gate. A read of address 2 returns the gate in bit 0 and 0 in bits 15:1.
- R7: `cpu_irq` is high exactly when the master gate is 1 and some bit is set in both enable and pending.
- R8: `halt_wake` is high exactly when some bit is set in both enable and pending, whatever the master gate is.
- R9: In a cycle with any `src_req` bit high, the lateness record becomes the larger of its stored value and `src_late`. In cycles with no request, `src_late` is ignored.
- R10: `late_val` always shows the stored lateness. A `late_take` pulse empties the record to 0. If a request arrives in the same cycle as the take, the record holds that request's `src_late` instead.
- R11: Address 3 reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 14 | Per-source request lines |
| src_late | input | 32 | Lateness reported with this cycle's requests |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| late_take | input | 1 | Empty the lateness record |
| late_val | output | 32 | Stored lateness |
| cpu_irq | output | 1 | Processor interrupt line |
| halt_wake | output | 1 | Wake-from-halt line |

## Verification
The assertions assume that inputs change only between clock edges and that `src_late` only has meaning in cycles where some request bit is high. The lateness property compares the record against the previous cycle's `src_late`, and only on request cycles. The bench drives every input just after a falling edge and returns all strobes to zero one step after the rising edge. Each bus access therefore covers exactly one edge, and no request is ever presented alone without a defined lateness value.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_ENABLE  = 2'd0,
    RA_PENDING = 2'd1,
    RA_MASTER  = 2'd2,
    RA_SPARE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NSRC = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] pend_q
);
  // set dominates clear so that no same-cycle event is lost
  function automatic logic [NSRC-1:0] pend_next(input logic [NSRC-1:0] cur,
                                                 input logic [NSRC-1:0] set,
                                                 input logic [NSRC-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_next(pend_q, set_vec, clr_vec)[i];
    end
  end
endmodule

// File: rtl/irq_late_track.sv
module irq_late_track #(
  parameter int LATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic [LATE_W-1:0] late_in,
  input  logic              take,
  output logic [LATE_W-1:0] late_q
);
  function automatic logic [LATE_W-1:0] late_next(input logic [LATE_W-1:0] cur,
                                                   input logic              smp,
                                                   input logic [LATE_W-1:0] nv,
                                                   input logic              tk);
    logic [LATE_W-1:0] base;
    base = tk ? '0 : cur;
    if (smp && nv > base) return nv;
    return base;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) late_q <= '0;
    else        late_q <= late_next(late_q, sample_en, late_in, take);
  end
endmodule

// File: rtl/irq_out_gate.sv
module irq_out_gate #(
  parameter int NSRC = 14
) (
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] pend_q,
  input  logic            master_q,
  output logic            cpu_irq,
  output logic            halt_wake
);
  logic [NSRC-1:0] active_vec;
  assign active_vec = en_q & pend_q;
  assign halt_wake  = |active_vec;
  assign cpu_irq    = halt_wake & master_q;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NSRC   = 14,
  parameter int LATE_W = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic [LATE_W-1:0] src_late,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              late_take,
  output logic [LATE_W-1:0] late_val,
  output logic              cpu_irq,
  output logic              halt_wake
);
  function automatic logic [DATA_W-1:0] widen(input logic [NSRC-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[NSRC-1:0] = v;
    return r;
  endfunction

  reg_addr_e       sel;
  logic            wr_enable, wr_pending, wr_master;
  logic [NSRC-1:0] en_q, pend_q, set_vec, clr_vec;
  logic            master_q;
  logic            late_sample;
  logic [LATE_W-1:0] late_q;

  assign sel        = reg_addr_e'(bus_addr);
  assign wr_enable  = bus_we && (sel == RA_ENABLE);
  assign wr_pending = bus_we && (sel == RA_PENDING);
  assign wr_master  = bus_we && (sel == RA_MASTER);

  assign set_vec     = src_req;
  assign clr_vec     = wr_pending ? bus_wdata[NSRC-1:0] : '0;
  assign late_sample = |src_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      master_q <= 1'b0;
    end else begin
      if (wr_enable) en_q     <= bus_wdata[NSRC-1:0];
      if (wr_master) master_q <= bus_wdata[0];
    end
  end

  irq_pend_bank #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .pend_q(pend_q)
  );

  irq_late_track #(.LATE_W(LATE_W)) u_late (
    .clk(clk), .rst_n(rst_n), .sample_en(late_sample), .late_in(src_late),
    .take(late_take), .late_q(late_q)
  );

  irq_out_gate #(.NSRC(NSRC)) u_gate (
    .en_q(en_q), .pend_q(pend_q), .master_q(master_q),
    .cpu_irq(cpu_irq), .halt_wake(halt_wake)
  );

  always_comb begin
    unique case (sel)
      RA_ENABLE:  bus_rdata = widen(en_q);
      RA_PENDING: bus_rdata = widen(pend_q);
      RA_MASTER:  bus_rdata = {{(DATA_W-1){1'b0}}, master_q};
      default:    bus_rdata = '0;
    endcase
  end

  assign late_val = late_q;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int NSRC   = 14,
  parameter int LATE_W = 32,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src_req,
  input logic [LATE_W-1:0] src_late,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              late_take,
  input logic [LATE_W-1:0] late_val,
  input logic [NSRC-1:0]   en_q,
  input logic [NSRC-1:0]   pend_q,
  input logic [NSRC-1:0]   clr_vec,
  input logic              master_q,
  input logic              cpu_irq,
  input logic              halt_wake
);
  AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_req) |=> ((pend_q & $past(src_req)) == $past(src_req))); // R5

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_vec)) & ~pend_q) == '0)); // R2

  AST_ENABLE_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[DATA_W-1:NSRC] == '0)); // R3

  AST_MASTER_READ_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd2) |-> (bus_rdata[DATA_W-1:1] == '0)); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (halt_wake && master_q)); // R7

  AST_WAKE_NO_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_q && ((en_q & pend_q) != '0)) |-> (halt_wake && !cpu_irq)); // R8

  AST_LATE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_req) |=> (late_val >= $past(src_late))); // R9

  AST_LATE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (late_take && !(|src_req)) |=> (late_val == '0)); // R10
endmodule

bind irq_hub irq_hub_chk #(.NSRC(NSRC), .LATE_W(LATE_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_late(src_late),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .late_take(late_take),
  .late_val(late_val), .en_q(en_q), .pend_q(pend_q), .clr_vec(clr_vec),
  .master_q(master_q), .cpu_irq(cpu_irq), .halt_wake(halt_wake)
);

// File: tb/tb_irq_hub.sv
module tb_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] src_req;
  logic [31:0] src_late;
  logic [1:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        late_take;
  logic [31:0] late_val;
  logic        cpu_irq, halt_wake;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  irq_hub dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_late(src_late),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .late_take(late_take), .late_val(late_val), .cpu_irq(cpu_irq), .halt_wake(halt_wake)
  );

  // entry: src[48:35] we[34] addr[33:32] wdata[31:16] pend[15:2] irq[1] wake[0]
  localparam logic [48:0] TBL [12] = '{
    {14'h0009, 1'b0, 2'd0, 16'h0000, 14'h0009, 1'b0, 1'b0},
    {14'h0000, 1'b1, 2'd0, 16'hFFFF, 14'h0009, 1'b0, 1'b1},
    {14'h0000, 1'b1, 2'd2, 16'h1234, 14'h0009, 1'b0, 1'b1},
    {14'h0000, 1'b1, 2'd2, 16'h1235, 14'h0009, 1'b1, 1'b1},
    {14'h0000, 1'b1, 2'd1, 16'h0008, 14'h0001, 1'b1, 1'b1},
    {14'h0000, 1'b1, 2'd1, 16'h0000, 14'h0001, 1'b1, 1'b1},
    {14'h0001, 1'b1, 2'd1, 16'h0001, 14'h0001, 1'b1, 1'b1},
    {14'h0000, 1'b1, 2'd1, 16'h0001, 14'h0000, 1'b0, 1'b0},
    {14'h2000, 1'b0, 2'd0, 16'h0000, 14'h2000, 1'b1, 1'b1},
    {14'h0000, 1'b1, 2'd0, 16'h0001, 14'h2000, 1'b0, 1'b0},
    {14'h0000, 1'b1, 2'd3, 16'hFFFF, 14'h2000, 1'b0, 1'b0},
    {14'h0000, 1'b1, 2'd1, 16'hFFFF, 14'h0000, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    src_req = '0; src_late = '0; bus_we = 1'b0; bus_wdata = '0; late_take = 1'b0;
  endtask

  task automatic cyc(input logic [13:0] s, input logic [31:0] lt, input logic we,
                     input logic [1:0] a, input logic [15:0] d, input logic tk);
    @(negedge clk);
    src_req = s; src_late = lt; bus_we = we; bus_addr = a; bus_wdata = d; late_take = tk;
    @(posedge clk);
    #1 idle();
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic reset_and_check(input string tag);
    logic [15:0] v;
    idle(); bus_addr = 2'd0; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk(tag, {16'h0, v}, 32'h0);
    end
    chk(tag, late_val, 32'h0);
    chk(tag, {31'h0, cpu_irq}, 32'h0);
    chk(tag, {31'h0, halt_wake}, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    reset_and_check("R1 reset");

    // table walk: R2 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < 12; i++) begin
      logic [48:0] e;
      e = TBL[i];
      cyc(e[48:35], 32'h0, e[34], e[33:32], e[31:16], 1'b0);
      rd(2'd1, v);
      chk("R2/R4/R5 pending", {16'h0, v}, {18'h0, e[15:2]});
      chk("R7 cpu_irq", {31'h0, cpu_irq}, {31'h0, e[1]});
      chk("R8 halt_wake", {31'h0, halt_wake}, {31'h0, e[0]});
    end

    // enable register masking R3, spare address R11, master readback R6
    rd(2'd0, v); chk("R3 enable after spare write", {16'h0, v}, 32'h0001);
    cyc('0, 0, 1'b1, 2'd0, 16'hFFFF, 1'b0);
    rd(2'd0, v); chk("R3 enable mask", {16'h0, v}, 32'h3FFF);
    rd(2'd3, v); chk("R11 spare reads zero", {16'h0, v}, 32'h0);
    rd(2'd2, v); chk("R6 master read", {16'h0, v}, 32'h0001);

    // all sources raised; pending bits 15:14 read zero R4
    cyc(14'h3FFF, 32'd0, 1'b0, 2'd0, 16'h0, 1'b0);
    rd(2'd1, v); chk("R4 pending all", {16'h0, v}, 32'h3FFF);
    chk("R8 wake with all", {31'h0, halt_wake}, 32'h1);
    cyc('0, 0, 1'b1, 2'd2, 16'hFFFE, 1'b0);
    chk("R7 master off", {31'h0, cpu_irq}, 32'h0);
    chk("R8 wake ignores master", {31'h0, halt_wake}, 32'h1);
    rd(2'd2, v); chk("R6 master bit0 only", {16'h0, v}, 32'h0);
    cyc('0, 0, 1'b1, 2'd1, 16'hFFFF, 1'b0);

    // lateness record R9 R10
    cyc(14'h0008, 32'd5, 1'b0, 2'd0, 16'h0, 1'b0);
    chk("R9 first lateness", late_val, 32'd5);
    cyc(14'h0010, 32'd3, 1'b0, 2'd0, 16'h0, 1'b0);
    chk("R9 keep max", late_val, 32'd5);
    cyc(14'h0000, 32'd9, 1'b0, 2'd0, 16'h0, 1'b0);
    chk("R9 ignored without request", late_val, 32'd5);
    cyc(14'h0100, 32'hF000_0009, 1'b0, 2'd0, 16'h0, 1'b0);
    chk("R9 larger wins", late_val, 32'hF000_0009);
    chk("R10 value visible before take", late_val, 32'hF000_0009);
    cyc('0, 0, 1'b0, 2'd0, 16'h0, 1'b1);
    chk("R10 take empties", late_val, 32'd0);
    cyc(14'h0001, 32'd7, 1'b0, 2'd0, 16'h0, 1'b0);
    cyc(14'h0002, 32'd4, 1'b0, 2'd0, 16'h0, 1'b1);
    chk("R10 take with request", late_val, 32'd4);

    reset_and_check("R1 second reset");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule